// File: doc/BRIEF.md
# Bulk IN Endpoint Transmit Buffer with Byte-Wide DMA Fill

This block holds outgoing data for one bulk IN endpoint in a set of packet banks (two by default). A DMA engine fills the current bank one byte per write strobe, paced by a request line. The request stays high as long as some bank has no committed data. The USB transmit engine sees the oldest committed packet through a ready flag, a length and a byte read port. A read strobe steps through the packet's bytes. A "transmitted" strobe then returns that bank to the free pool.

A bank is committed in one of two ways. When its last byte slot is written, the bank becomes ready on its own, with no firmware action. A shorter packet waits until firmware pulses a packet-enable strobe. A packet-enable strobe on a bank with no bytes in it sends a zero-length packet. Committed banks go out in the order they were committed.

Top module: `usb_in_dma_fifo`

## Requirements
- R1: Out of reset, no packet is ready (`pkt_rdy` low) and the DMA request (`dma_req`) is high.
- R2: Accepting the byte that fills the current bank to `MAX_PKT` (64) bytes commits the bank without any `pkt_en`. From the next cycle the packet is visible with `pkt_len` = 64, once the packets committed before it have been sent.
- R3: A bank holding fewer than `MAX_PKT` bytes is not presented while `pkt_en` stays low. A `pkt_en` pulse commits it, and `pkt_len` then equals the number of bytes written.
- R4: A `pkt_en` pulse when the current fill bank holds no bytes commits a zero-length packet (`pkt_rdy` high, `pkt_len` = 0).
- R5: `dma_req` is low exactly while every bank is committed and waiting. It returns high in the cycle after `tx_done` frees a bank.
- R6: Packets are presented in commit order. `rd_data` shows the byte at the current read index, starting at the packet's first byte. Each `rd_en` pulse advances the index by one and stops at the last byte.
- R7: `tx_done` frees the oldest committed bank and resets the read index. A `tx_done` while no packet is ready has no effect.
- R8: While no bank is free, `pkt_en` and `dma_wr` are ignored. They add neither a packet nor a byte.
- R9: When `dma_wr` and `pkt_en` arrive in the same cycle, the byte is part of the committed packet and exactly one packet is committed, including when that byte is the 64th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | output | 1 | A bank is free to be filled |
| dma_wr | input | 1 | DMA byte write strobe |
| dma_data | input | 8 | DMA write byte |
| pkt_en | input | 1 | Firmware strobe that commits a short packet |
| pkt_rdy | output | 1 | Oldest committed packet is available |
| pkt_len | output | 7 | Byte count of the presented packet (0..64) |
| rd_en | input | 1 | Advance the read index by one byte |
| rd_data | output | 8 | Byte at the current read index |
| tx_done | input | 1 | Presented packet was transmitted; free its bank |

## Verification
The bench builds the block with its defaults: 64-byte packets, two banks and byte-wide data. This means the real automatic-commit boundary at the 64th byte is exercised, not a scaled-down stand-in. With only two banks, a single full packet plus one short one is enough to reach the all-committed state, where the request drops and stray strobes must be ignored. The same setup puts the case of a byte and packet-enable arriving in the same cycle directly on the 64-byte edge, and it makes commit-order wraparound across the bank ring happen several times within one run.

// File: rtl/txb_pkg.sv
package txb_pkg;

    localparam int TXB_MAX_PKT_DEF = 64;
    localparam int TXB_BANKS_DEF   = 2;
    localparam int TXB_BYTE_W      = 8;

    // Reason a bank was handed to the transmit side this cycle.
    typedef enum logic [1:0] {
        CMT_NONE  = 2'd0,
        CMT_FULL  = 2'd1,
        CMT_SHORT = 2'd2
    } commit_e;

    // Step a ring pointer over n entries.
    function automatic int wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/txb_bank_mem.sv
module txb_bank_mem #(
    parameter int NUM_BANKS = 2,
    parameter int DEPTH     = 64,
    parameter int DW        = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BANK_W-1:0] wbank,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DW-1:0]     wdata,
    input  logic [BANK_W-1:0] rbank,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DW-1:0]     rdata
);
    localparam int ENTRIES = NUM_BANKS * DEPTH;
    localparam int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [DW-1:0] mem_q [ENTRIES];
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    always_comb begin
        waddr = AW'(wbank) * AW'(DEPTH) + AW'(widx);
        raddr = AW'(rbank) * AW'(DEPTH) + AW'(ridx);
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/txb_fill_ctrl.sv
module txb_fill_ctrl
    import txb_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int MAX_PKT   = 64,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int IDX_W    = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int LEN_W    = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              space,
    input  logic              dma_wr,
    input  logic              pkt_en,
    output logic              wr_en,
    output logic [BANK_W-1:0] fill_bank,
    output logic [IDX_W-1:0]  fill_idx,
    output commit_e           commit_kind,
    output logic [LEN_W-1:0]  commit_len
);
    logic [BANK_W-1:0] bank_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              acc_wr;
    logic              acc_en;
    logic              last_slot;

    always_comb begin
        acc_wr     = dma_wr && space;
        acc_en     = pkt_en && space;
        last_slot  = (cnt_q == IDX_W'(MAX_PKT - 1));
        commit_len = LEN_W'(cnt_q) + LEN_W'(acc_wr);
        if (acc_wr && last_slot) begin
            commit_kind = CMT_FULL;
        end else if (acc_en) begin
            commit_kind = CMT_SHORT;
        end else begin
            commit_kind = CMT_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            cnt_q  <= '0;
        end else if (commit_kind != CMT_NONE) begin
            bank_q <= BANK_W'(wrap_inc(int'(bank_q), NUM_BANKS));
            cnt_q  <= '0;
        end else if (acc_wr) begin
            cnt_q  <= cnt_q + IDX_W'(1);
        end
    end

    assign wr_en     = acc_wr;
    assign fill_bank = bank_q;
    assign fill_idx  = cnt_q;

endmodule

// File: rtl/txb_queue_ctrl.sv
module txb_queue_ctrl
    import txb_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int MAX_PKT   = 64,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int IDX_W    = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int LEN_W    = $clog2(MAX_PKT + 1),
    localparam int OCC_W    = $clog2(NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  commit_e           commit_kind,
    input  logic [BANK_W-1:0] commit_bank,
    input  logic [LEN_W-1:0]  commit_len,
    input  logic              rd_en,
    input  logic              tx_done,
    output logic              space,
    output logic              pkt_rdy,
    output logic [LEN_W-1:0]  pkt_len,
    output logic [BANK_W-1:0] send_bank,
    output logic [IDX_W-1:0]  rd_idx
);
    logic [OCC_W-1:0]  occ_q;
    logic [BANK_W-1:0] send_q;
    logic [IDX_W-1:0]  ridx_q;
    logic [LEN_W-1:0]  len_vec [NUM_BANKS];
    logic              commit_v;
    logic              release_v;

    assign commit_v  = (commit_kind != CMT_NONE);
    assign pkt_rdy   = (occ_q != '0);
    assign space     = (occ_q != OCC_W'(NUM_BANKS));
    assign release_v = tx_done && pkt_rdy;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_len
        logic [LEN_W-1:0] len_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                len_r <= '0;
            end else if (commit_v && commit_bank == BANK_W'(b)) begin
                len_r <= commit_len;
            end
        end
        assign len_vec[b] = len_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            case ({commit_v, release_v})
                2'b10:   occ_q <= occ_q + OCC_W'(1);
                2'b01:   occ_q <= occ_q - OCC_W'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            send_q <= '0;
            ridx_q <= '0;
        end else if (release_v) begin
            send_q <= BANK_W'(wrap_inc(int'(send_q), NUM_BANKS));
            ridx_q <= '0;
        end else if (rd_en && pkt_rdy &&
                     (LEN_W'(ridx_q) + LEN_W'(1) < pkt_len)) begin
            ridx_q <= ridx_q + IDX_W'(1);
        end
    end

    assign pkt_len   = len_vec[send_q];
    assign send_bank = send_q;
    assign rd_idx    = ridx_q;

endmodule

// File: rtl/usb_in_dma_fifo.sv
module usb_in_dma_fifo
    import txb_pkg::*;
#(
    parameter int MAX_PKT   = TXB_MAX_PKT_DEF,
    parameter int NUM_BANKS = TXB_BANKS_DEF,
    parameter int DATA_W    = TXB_BYTE_W,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int IDX_W    = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int LEN_W    = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              dma_req,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              pkt_en,
    output logic              pkt_rdy,
    output logic [LEN_W-1:0]  pkt_len,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_done
);
    logic              space;
    logic              wr_en;
    logic [BANK_W-1:0] fill_bank;
    logic [IDX_W-1:0]  fill_idx;
    commit_e           commit_kind;
    logic [LEN_W-1:0]  commit_len;
    logic [BANK_W-1:0] send_bank;
    logic [IDX_W-1:0]  rd_idx;

    txb_fill_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .MAX_PKT   (MAX_PKT)
    ) u_fill (
        .clk         (clk),
        .rst         (rst),
        .space       (space),
        .dma_wr      (dma_wr),
        .pkt_en      (pkt_en),
        .wr_en       (wr_en),
        .fill_bank   (fill_bank),
        .fill_idx    (fill_idx),
        .commit_kind (commit_kind),
        .commit_len  (commit_len)
    );

    txb_queue_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .MAX_PKT   (MAX_PKT)
    ) u_queue (
        .clk         (clk),
        .rst         (rst),
        .commit_kind (commit_kind),
        .commit_bank (fill_bank),
        .commit_len  (commit_len),
        .rd_en       (rd_en),
        .tx_done     (tx_done),
        .space       (space),
        .pkt_rdy     (pkt_rdy),
        .pkt_len     (pkt_len),
        .send_bank   (send_bank),
        .rd_idx      (rd_idx)
    );

    txb_bank_mem #(
        .NUM_BANKS (NUM_BANKS),
        .DEPTH     (MAX_PKT),
        .DW        (DATA_W)
    ) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .wbank (fill_bank),
        .widx  (fill_idx),
        .wdata (dma_data),
        .rbank (send_bank),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    assign dma_req = space;

endmodule

// File: rtl/txb_checker.sv
module txb_checker #(
    parameter int MAX_PKT  = 64,
    localparam int IDX_W   = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int LEN_W   = $clog2(MAX_PKT + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             dma_req,
    input logic             dma_wr,
    input logic             pkt_en,
    input logic             pkt_rdy,
    input logic [LEN_W-1:0] pkt_len,
    input logic             tx_done,
    input logic [IDX_W-1:0] fill_idx
);
    logic fill_last;
    assign fill_last = dma_wr && dma_req && (fill_idx == IDX_W'(MAX_PKT - 1));

    // R1
    a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dma_req && !pkt_rdy));

    // R2
    a_r2_auto_commit: assert property (@(posedge clk) disable iff (rst)
        fill_last |=> pkt_rdy);

    // R3
    a_r3_no_spurious_ready: assert property (@(posedge clk) disable iff (rst)
        (!pkt_rdy && !pkt_en && !fill_last) |=> !pkt_rdy);

    // R5
    a_r5_full_implies_ready: assert property (@(posedge clk) disable iff (rst)
        !dma_req |-> pkt_rdy);

    // R5
    a_r5_req_holds: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_wr && !pkt_en) |=> dma_req);

    // R6
    a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
        pkt_rdy |-> (pkt_len <= LEN_W'(MAX_PKT)));

    // R7
    a_r7_head_stable: assert property (@(posedge clk) disable iff (rst)
        (pkt_rdy && !tx_done) |=> (pkt_rdy && $stable(pkt_len)));

endmodule

bind usb_in_dma_fifo txb_checker #(.MAX_PKT(MAX_PKT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dma_req  (dma_req),
    .dma_wr   (dma_wr),
    .pkt_en   (pkt_en),
    .pkt_rdy  (pkt_rdy),
    .pkt_len  (pkt_len),
    .tx_done  (tx_done),
    .fill_idx (fill_idx)
);

// File: tb/usb_in_dma_fifo_tb.sv
`timescale 1ns/1ps
module usb_in_dma_fifo_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dma_req;
    logic       dma_wr = 1'b0;
    logic [7:0] dma_data = 8'h00;
    logic       pkt_en = 1'b0;
    logic       pkt_rdy;
    logic [6:0] pkt_len;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tx_done = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] exp_bytes[$];
    int         exp_lens[$];

    always #2.5 clk = ~clk;

    usb_in_dma_fifo u_dut (
        .clk      (clk),
        .rst      (rst),
        .dma_req  (dma_req),
        .dma_wr   (dma_wr),
        .dma_data (dma_data),
        .pkt_en   (pkt_en),
        .pkt_rdy  (pkt_rdy),
        .pkt_len  (pkt_len),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .tx_done  (tx_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr_byte(input logic [7:0] b, input bit with_en);
        dma_wr   = 1'b1;
        dma_data = b;
        pkt_en   = with_en;
        @(negedge clk);
        dma_wr = 1'b0;
        pkt_en = 1'b0;
    endtask

    task automatic pulse_en();
        pkt_en = 1'b1;
        @(negedge clk);
        pkt_en = 1'b0;
    endtask

    task automatic pulse_done();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    // Driver: writes a packet and records what the transmit side must see.
    task automatic send_pkt(input int len, input int base, input bit commit_en);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'((base + i) & 8'hff);
            exp_bytes.push_back(b);
            wr_byte(b, 1'b0);
        end
        if (commit_en) pulse_en();
        exp_lens.push_back(len);
    endtask

    // Monitor: pops the oldest expected packet and compares it.
    task automatic drain_pkt(input string req);
        int len;
        len = exp_lens.pop_front();
        check(pkt_rdy == 1'b1, req, int'(pkt_rdy), 1);
        check(int'(pkt_len) == len, req, int'(pkt_len), len);
        for (int i = 0; i < len; i++) begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            check(rd_data == e, "R6", int'(rd_data), int'(e));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        pulse_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(dma_req == 1'b1, "R1", int'(dma_req), 1);
        check(pkt_rdy == 1'b0, "R1", int'(pkt_rdy), 0);

        // R3 short packet waits for pkt_en
        for (int i = 0; i < 10; i++) begin
            exp_bytes.push_back(8'(8'h10 + i));
            wr_byte(8'(8'h10 + i), 1'b0);
        end
        check(pkt_rdy == 1'b0, "R3", int'(pkt_rdy), 0);
        pulse_en();
        exp_lens.push_back(10);
        check(pkt_len == 7'd10, "R3", int'(pkt_len), 10);
        drain_pkt("R3");
        check(pkt_rdy == 1'b0, "R7", int'(pkt_rdy), 0);

        // R2 automatic commit at 64 bytes
        send_pkt(64, 8'h40, 1'b0);
        check(pkt_rdy == 1'b1 && pkt_len == 7'd64, "R2", int'(pkt_len), 64);
        drain_pkt("R2");

        // R4 zero-length packet
        pulse_en();
        exp_lens.push_back(0);
        check(pkt_rdy == 1'b1, "R4", int'(pkt_rdy), 1);
        check(pkt_len == 7'd0, "R4", int'(pkt_len), 0);
        drain_pkt("R4");
        check(pkt_rdy == 1'b0, "R4", int'(pkt_rdy), 0);

        // R5/R8 both banks committed
        send_pkt(64, 8'h80, 1'b0);
        send_pkt(5, 8'hc0, 1'b1);
        check(dma_req == 1'b0, "R5", int'(dma_req), 0);
        pulse_en();
        wr_byte(8'hee, 1'b0);
        check(dma_req == 1'b0, "R8", int'(dma_req), 0);
        drain_pkt("R6");
        check(dma_req == 1'b1, "R5", int'(dma_req), 1);
        drain_pkt("R6");
        check(pkt_rdy == 1'b0, "R8", int'(pkt_rdy), 0);
        pulse_en();
        check(pkt_len == 7'd0, "R8", int'(pkt_len), 0);
        exp_lens.push_back(0);
        drain_pkt("R8");

        // R9 byte and pkt_en together, short case
        exp_bytes.push_back(8'h01); wr_byte(8'h01, 1'b0);
        exp_bytes.push_back(8'h02); wr_byte(8'h02, 1'b0);
        exp_bytes.push_back(8'h03); wr_byte(8'h03, 1'b1);
        exp_lens.push_back(3);
        check(pkt_len == 7'd3, "R9", int'(pkt_len), 3);
        drain_pkt("R9");

        // R9 byte and pkt_en together on the 64th byte
        for (int i = 0; i < 64; i++) begin
            exp_bytes.push_back(8'(8'h20 + i));
            wr_byte(8'(8'h20 + i), i == 63);
        end
        exp_lens.push_back(64);
        drain_pkt("R9");
        check(pkt_rdy == 1'b0, "R9", int'(pkt_rdy), 0);

        // R7 tx_done with nothing ready is ignored
        pulse_done();
        check(pkt_rdy == 1'b0 && dma_req == 1'b1, "R7", int'(pkt_rdy), 0);
        send_pkt(4, 8'h70, 1'b1);
        send_pkt(2, 8'h90, 1'b1);
        drain_pkt("R7");
        drain_pkt("R6");
        check(pkt_rdy == 1'b0, "R7", int'(pkt_rdy), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule